// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

A synchronous single-port memory in which every command is registered and then moves through a two-stage pipeline. Read data leaves the core two clock edges after its command is captured. Write data is taken from the bus at the same distance, so the bus carries read slots and write slots in the same rhythm. Reads and writes can therefore be interleaved in any order with no idle cycles between them.

A command is loaded with the advance/load strobe low. Holding that strobe high continues the current burst. The low two address bits then step through a four-beat sequence, in interleaved or linear order as a parameter selects. An active-low clock enable freezes the whole core. An asynchronous output enable gates the output driver. The bidirectional data bus is modelled as separate input data, output data and driver-enable ports.

Top module: `zt_sram`

## Requirements
- R1: A synchronous active-high reset empties both pipeline stages and the output stage, so `dq_oe` is low after reset and no write is pending.
- R2: A read loaded at clock edge N puts the array word on `dout` after edge N+2, and holds it there until the next enabled edge.
- R3: A write loaded at edge N stores `din`, as sampled at edge N+2, into the addressed word. A later read returns the stored value.
- R4: On a load cycle the core is selected only when `ce0_n`=0, `ce1`=1 and `ce2_n`=0. Any other combination is a deselect: nothing is stored and the output is not driven two edges later.
- R5: Reads and writes may follow each other on consecutive cycles in any order, including a read of the address written one cycle before, and each read returns the most recently written data.
- R6: With `adv_ld`=1 the inputs `addr`, the chip enables and `rd_wrn` are ignored. The burst keeps its first cycle's operation type, and beat k (k=1..3, wrapping after four beats) uses low address bits start XOR k when `LINEAR_BURST`=0, or start+k mod 4 when `LINEAR_BURST`=1. The upper address bits are unchanged.
- R7: A continue cycle that follows a deselect is itself a deselect.
- R8: `bw_n[0]` (active low) enables the low byte `din[8:0]` and `bw_n[1]` enables the high byte `din[17:9]`, sampled with the write data. With both high the write is aborted and stores nothing, yet the burst address still advances.
- R9: While `cen_n`=1 all state holds: no write occurs, `dout` and `dq_oe` keep their values, and no command is captured.
- R10: `dq_oe` is high exactly when the output stage holds read data and `oe_n` is low, with `oe_n` acting without a clock. The driver is off in write slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Clock enable, active low |
| adv_ld | input | 1 | 1 = continue burst, 0 = load new command |
| rd_wrn | input | 1 | On load: 1 = read, 0 = write |
| addr | input | AW | Word address, captured on load |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| bw_n | input | 2 | Byte write enables, active low, sampled with write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | DW | Bus data toward the core |
| dout | output | DW | Bus data from the output stage |
| dq_oe | output | 1 | Bus driver enable |

## Verification
The embedded assertions check, on every cycle, the properties that can be stated locally. A stalled clock freezes the output stage and the pipeline. A deselect load, or a continue after a deselect, never fills the first stage. A continue never changes the burst type. A write slot never turns on the driver. Output data only appears behind a read in the second stage. Whether the stored and returned data are right can only be shown by the bench scenarios, which compare each read against a reference memory. These cover byte masking and write abort, the burst address order, back-to-back read and write of one address, stalls in mid-burst, and decode of every chip-enable combination.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int AW = 6,
  parameter int DW = 18,
  parameter bit LINEAR_BURST = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cen_n,
  input  logic          adv_ld,
  input  logic          rd_wrn,
  input  logic [AW-1:0] addr,
  input  logic          ce0_n,
  input  logic          ce1,
  input  logic          ce2_n,
  input  logic [1:0]    bw_n,
  input  logic          oe_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dq_oe
);
  localparam int DEPTH = 1 << AW;
  localparam int LB    = DW / 2;
  localparam logic [1:0] K_NONE = 2'd0, K_RD = 2'd1, K_WR = 2'd2;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] base;
  logic [1:0]    bcnt, kind;
  logic          s1_v, s1_wr, s2_v, s2_wr, q_v;
  logic [AW-1:0] s1_addr, s2_addr;
  logic [DW-1:0] q_data;
  logic [1:0]    nidx, blo;
  logic          sel;

  assign sel  = ~ce0_n & ce1 & ~ce2_n;
  assign nidx = bcnt + 2'd1;

  generate
    if (LINEAR_BURST) begin : g_lin
      assign blo = base[1:0] + nidx;
    end else begin : g_ilv
      assign blo = base[1:0] ^ nidx;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s2_v <= 1'b0; q_v <= 1'b0;
      kind <= K_NONE; bcnt <= 2'd0;
      s1_wr <= 1'b0; s2_wr <= 1'b0;
      base <= '0; s1_addr <= '0; s2_addr <= '0;
    end else if (!cen_n) begin
      if (!adv_ld) begin
        base    <= addr;
        bcnt    <= 2'd0;
        kind    <= sel ? (rd_wrn ? K_RD : K_WR) : K_NONE;
        s1_v    <= sel;
        s1_wr   <= ~rd_wrn;
        s1_addr <= addr;
      end else begin
        bcnt    <= nidx;
        s1_v    <= (kind != K_NONE);
        s1_wr   <= (kind == K_WR);
        s1_addr <= {base[AW-1:2], blo};
      end
      s2_v    <= s1_v;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      q_v     <= s2_v & ~s2_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && !cen_n && s2_v) begin
      if (s2_wr) begin
        if (!bw_n[0]) mem[s2_addr][LB-1:0]  <= din[LB-1:0];
        if (!bw_n[1]) mem[s2_addr][DW-1:LB] <= din[DW-1:LB];
      end else begin
        q_data <= mem[s2_addr];
      end
    end
  end

  assign dout  = q_data;
  assign dq_oe = q_v & ~oe_n;

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !q_v && !s2_v && !s1_v);
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (rst)
    cen_n |=> $stable(q_v) && $stable(q_data) && $stable(s2_v) && $stable(s1_v));
  a_r10_write_slot_off: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && s2_v && s2_wr) |=> !dq_oe);
  a_r2_data_from_read: assert property (@(posedge clk) disable iff (rst)
    $rose(q_v) |-> $past(s2_v && !s2_wr));
  a_r4_deselect_empty: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && !adv_ld && !sel) |=> !s1_v);
  a_r7_cont_deselect: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && adv_ld && kind == K_NONE) |=> !s1_v);
  a_r6_type_kept: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && adv_ld) |=> $stable(kind));
endmodule

// File: tb/test_zt_sram.sv
module test_zt_sram;
  localparam int AW = 6, DW = 18, DEPTH = 1 << AW;

  logic clk = 0, rst = 1, cen_n = 0, adv_ld = 0, rd_wrn = 1;
  logic [AW-1:0] addr = '0;
  logic ce0_n = 1, ce1 = 0, ce2_n = 1, oe_n = 0;
  logic [1:0] bw_n = 2'b00;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dq_oe;

  zt_sram #(.AW(AW), .DW(DW), .LINEAR_BURST(1'b0)) i_zt_sram (
    .clk(clk), .rst(rst), .cen_n(cen_n), .adv_ld(adv_ld), .rd_wrn(rd_wrn),
    .addr(addr), .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .bw_n(bw_n),
    .oe_n(oe_n), .din(din), .dout(dout), .dq_oe(dq_oe));

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;
  string tag = "R1";

  logic [DW-1:0] mm [DEPTH];
  logic [AW-1:0] m_base;
  logic [1:0] m_cnt;
  int m_kind;
  logic m_s1v, m_s1w, m_s2v, m_s2w, m_qv;
  logic [AW-1:0] m_s1a, m_s2a;
  logic [DW-1:0] m_q;

  function automatic logic [AW-1:0] burst_addr(logic [AW-1:0] b, logic [1:0] k);
    return {b[AW-1:2], b[1:0] ^ k};
  endfunction

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic model_update();
    logic sel;
    if (cen_n) return;
    if (m_s2v && m_s2w) begin
      if (!bw_n[0]) mm[m_s2a][8:0]  = din[8:0];
      if (!bw_n[1]) mm[m_s2a][17:9] = din[17:9];
    end
    if (m_s2v && !m_s2w) m_q = mm[m_s2a];
    m_qv = m_s2v && !m_s2w;
    m_s2v = m_s1v; m_s2w = m_s1w; m_s2a = m_s1a;
    if (!adv_ld) begin
      sel = !ce0_n && ce1 && !ce2_n;
      m_base = addr; m_cnt = 0;
      m_kind = sel ? (rd_wrn ? 1 : 2) : 0;
      m_s1v = sel; m_s1w = !rd_wrn; m_s1a = addr;
    end else begin
      m_cnt = m_cnt + 2'd1;
      m_s1v = (m_kind != 0); m_s1w = (m_kind == 2);
      m_s1a = burst_addr(m_base, m_cnt);
    end
  endtask

  task automatic check_out();
    chk(tag, {31'd0, dq_oe}, {31'd0, m_qv && !oe_n});
    if (m_qv && !oe_n) chk(tag, {14'd0, dout}, {14'd0, m_q});
  endtask

  task automatic op(logic c, logic adv, logic rw, logic [AW-1:0] a,
                    logic [2:0] ce, logic [1:0] bw, logic oe);
    cen_n = c; adv_ld = adv; rd_wrn = rw; addr = a;
    {ce0_n, ce1, ce2_n} = ce; bw_n = bw; oe_n = oe;
    din = DW'($urandom);
    model_update();
    @(negedge clk);
    check_out();
  endtask

  localparam logic [2:0] SEL = 3'b010, DES = 3'b111;

  initial begin
    #1_000_000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_s1v = 0; m_s2v = 0; m_qv = 0; m_kind = 0; m_cnt = 0;
    m_s1w = 0; m_s2w = 0; m_s1a = 0; m_s2a = 0; m_base = 0; m_q = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R1";
    chk("R1", {31'd0, dq_oe}, 32'd0);
    repeat (3) op(0, 0, 1, '0, DES, 2'b00, 0);

    tag = "R3";
    for (int i = 0; i < DEPTH; i++) op(0, 0, 0, AW'(i), SEL, 2'b00, 0);
    repeat (2) op(0, 0, 1, '0, DES, 2'b00, 0);

    tag = "R2";
    for (int i = 0; i < 8; i++) op(0, 0, 1, AW'(i * 7), SEL, 2'b11, 0);
    repeat (3) op(0, 0, 1, '0, DES, 2'b11, 0);

    tag = "R5";
    for (int i = 0; i < 6; i++) begin
      op(0, 0, 0, AW'(20 + i), SEL, 2'b00, 0);
      op(0, 0, 1, AW'(20 + i), SEL, 2'b00, 0);
      op(0, 0, 1, AW'(30 + i), SEL, 2'b00, 0);
      op(0, 0, 0, AW'(30 + i), SEL, 2'b00, 0);
    end
    repeat (3) op(0, 0, 1, '0, DES, 2'b00, 0);

    tag = "R4";
    for (int c = 0; c < 8; c++) op(0, 0, 0, AW'(40 + c), 3'(c), 2'b00, 0);
    for (int c = 0; c < 8; c++) op(0, 0, 1, AW'(40 + c), 3'(c), 2'b00, 0);
    for (int c = 0; c < 8; c++) op(0, 0, 1, AW'(40 + c), SEL, 2'b00, 0);
    repeat (3) op(0, 0, 1, '0, DES, 2'b00, 0);

    tag = "R6";
    op(0, 0, 0, AW'(13), SEL, 2'b00, 0);
    for (int k = 0; k < 6; k++) op(0, 1, 1, AW'($urandom), 3'($urandom), 2'b00, 0);
    op(0, 0, 1, AW'(14), SEL, 2'b00, 0);
    for (int k = 0; k < 5; k++) op(0, 1, 0, AW'($urandom), 3'($urandom), 2'b00, 0);
    repeat (3) op(0, 0, 1, '0, DES, 2'b00, 0);

    tag = "R7";
    op(0, 0, 0, AW'(50), DES, 2'b00, 0);
    for (int k = 0; k < 4; k++) op(0, 1, 0, AW'($urandom), SEL, 2'b00, 0);
    op(0, 0, 1, AW'(50), SEL, 2'b00, 0);
    op(0, 1, 0, '0, SEL, 2'b00, 0);
    repeat (3) op(0, 0, 1, '0, DES, 2'b00, 0);

    tag = "R8";
    op(0, 0, 0, AW'(60), SEL, 2'b10, 0);
    op(0, 0, 0, AW'(61), SEL, 2'b01, 0);
    op(0, 0, 0, AW'(62), SEL, 2'b11, 0);
    op(0, 1, 0, '0, DES, 2'b11, 0);
    op(0, 1, 0, '0, DES, 2'b00, 0);
    op(0, 0, 1, AW'(60), SEL, 2'b00, 0);
    for (int k = 0; k < 3; k++) op(0, 1, 1, '0, DES, 2'b00, 0);
    op(0, 0, 1, AW'(61), SEL, 2'b00, 0);
    repeat (3) op(0, 0, 1, '0, DES, 2'b00, 0);

    tag = "R9";
    op(0, 0, 1, AW'(5), SEL, 2'b00, 0);
    op(0, 0, 0, AW'(6), SEL, 2'b00, 0);
    op(0, 0, 1, AW'(6), SEL, 2'b00, 0);
    for (int k = 0; k < 3; k++) op(1, 0, 0, AW'(5), SEL, 2'b00, 0);
    op(0, 0, 1, AW'(6), SEL, 2'b00, 0);
    op(1, 1, 0, '0, SEL, 2'b00, 0);
    repeat (4) op(0, 0, 1, '0, DES, 2'b00, 0);

    tag = "R10";
    for (int k = 0; k < 40; k++)
      op(0, 0, 1'($urandom), AW'($urandom), SEL, 2'b00, 1'($urandom));
    repeat (3) op(0, 0, 1, '0, DES, 2'b00, 0);

    tag = "R5";
    for (int k = 0; k < 3000; k++) begin
      logic adv;
      adv = ($urandom % 3) == 0;
      op(($urandom % 8) == 0, adv, 1'($urandom), AW'($urandom),
         (($urandom % 5) == 0) ? 3'($urandom) : SEL, 2'($urandom),
         ($urandom % 6) == 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule